// File: doc/BRIEF.md
# Retentive Up/Down Event Counter

This block counts events on two level inputs: one that adds and one that subtracts. It reacts only when an input goes from low to high, so a push button held down or a maintained contact adds a single count. The signed 16-bit accumulator keeps its value for as long as no new edge arrives. Only the synchronous system reset or the dedicated clear input zeroes it.

A signed preset is compared with the accumulator at all times, and a done flag reports when the count has reached or passed it. Counting goes on after done is set. When the count steps past the largest positive value, or below the most negative one, it wraps around and raises a sticky overflow or underflow flag. A single 16-bit status word carries all flags at fixed bit positions, so that control logic elsewhere can decode it.

Top module: `evt_counter`

## Requirements
- R1: A low-to-high change of `cnt_up` adds one to `acc_o` at the clock edge where the high level is first sampled. An input held high adds only once.
- R2: A low-to-high change of `cnt_dn` subtracts one from `acc_o` at the clock edge where the high level is first sampled. An input held high subtracts only once.
- R3: When both inputs rise at the same clock edge, `acc_o` and the overflow and underflow flags are unchanged.
- R4: With no rising edge and no clear, `acc_o` keeps its value.
- R5: Status bit 13 (done) is 1 exactly when the signed value of `acc_o` is greater than or equal to the signed value of `preset`. This holds for negative presets and counts too.
- R6: Counting up from +32767 gives -32768 and sets status bit 12 (overflow). The bit then stays set through further counting until a clear or reset.
- R7: Counting down from -32768 gives +32767 and sets status bit 11 (underflow). The bit then stays set through further counting until a clear or reset.
- R8: At a clock edge with `clr` high, `acc_o` becomes 0 and status bits 12, 11 and 10 become 0. A count edge in the same cycle is discarded.
- R9: In the status word, bit 15 follows the current level of `cnt_up` and bit 14 follows the current level of `cnt_dn`. Bits 9..0 always read 0.
- R10: Status bit 10 (update) is 1 for exactly the cycle after a clock edge at which a count changed `acc_o`, and 0 otherwise.
- R11: After `rst` with both count inputs low, `acc_o` is 0 and the status word is 0. An input found high at the first edge after reset counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also clears the edge history |
| cnt_up | input | 1 | Count-up level input |
| cnt_dn | input | 1 | Count-down level input |
| clr | input | 1 | Counter clear |
| preset | input | 16 | Signed compare value for done |
| acc_o | output | 16 | Signed accumulator |
| status | output | 16 | Flag word: 15 up level, 14 down level, 13 done, 12 overflow, 11 underflow, 10 update, 9..0 zero |

## Verification
A stale edge history is the most likely internal error. It would show at the next count edge as a missing step or a doubled step in `acc_o`, one cycle after the input rises. A wrong wrap or a flag that does not stick shows at the boundary edge itself, and at every later edge up to the next clear. A reference model in the bench predicts the accumulator and the whole status word after every single clock. This catches any of these faults in the cycle where it first appears, including the effect of a wrong count on done.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    localparam int STATUS_W = 16;
    localparam int BIT_UP   = 15;
    localparam int BIT_DN   = 14;
    localparam int BIT_DONE = 13;
    localparam int BIT_OVF  = 12;
    localparam int BIT_UNF  = 11;
    localparam int BIT_UPD  = 10;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic up_lvl;
        logic dn_lvl;
        logic done;
        logic ovf;
        logic unf;
        logic upd;
    } flags_t;

    // Opposing edges in one cycle cancel each other.
    function automatic step_e pick_step(input logic rise_up, input logic rise_dn);
        if (rise_up && !rise_dn) return STEP_INC;
        if (rise_dn && !rise_up) return STEP_DEC;
        return STEP_NONE;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input flags_t f);
        logic [STATUS_W-1:0] w;
        w           = '0;
        w[BIT_UP]   = f.up_lvl;
        w[BIT_DN]   = f.dn_lvl;
        w[BIT_DONE] = f.done;
        w[BIT_OVF]  = f.ovf;
        w[BIT_UNF]  = f.unf;
        w[BIT_UPD]  = f.upd;
        return w;
    endfunction

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end

        assign rise[i] = lvl[i] & ~prev_q[i];

        // R1/R2: a level held high yields one edge only
        a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
            (rise[i] && lvl[i]) |=> !rise[i]);
    end

endmodule

// File: rtl/evt_acc_core.sv
module evt_acc_core
    import evt_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  step_e        step,
    output logic [W-1:0] acc,
    output logic         ovf,
    output logic         unf,
    output logic         upd
);
    localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE     = W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
            upd <= 1'b0;
        end else begin
            upd <= 1'b0;
            unique case (step)
                STEP_INC: begin
                    upd <= 1'b1;
                    if (acc == ACC_MAX) begin
                        acc <= ACC_MIN;
                        ovf <= 1'b1;
                    end else begin
                        acc <= acc + ONE;
                    end
                end
                STEP_DEC: begin
                    upd <= 1'b1;
                    if (acc == ACC_MIN) begin
                        acc <= ACC_MAX;
                        unf <= 1'b1;
                    end else begin
                        acc <= acc - ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_INC && !clr) |=> (acc == $past(acc) + ONE));

    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DEC && !clr) |=> (acc == $past(acc) - ONE));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_NONE && !clr) |=> $stable(acc));

    a_r6_wrap_high: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_INC && !clr && acc == ACC_MAX) |=> (ovf && acc == ACC_MIN));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        (unf && !clr) |=> unf);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0 && !ovf && !unf && !upd));

endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evt_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_up,
    input  logic                cnt_dn,
    input  logic                clr,
    input  logic [W-1:0]        preset,
    output logic [W-1:0]        acc_o,
    output logic [STATUS_W-1:0] status
);
    logic [1:0] rise;
    step_e      step;
    logic       ovf, unf, upd;
    flags_t     flags;

    evt_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({cnt_dn, cnt_up}),
        .rise (rise)
    );

    assign step = pick_step(rise[0], rise[1]);

    evt_acc_core #(.W(W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (step),
        .acc  (acc_o),
        .ovf  (ovf),
        .unf  (unf),
        .upd  (upd)
    );

    always_comb begin
        flags.up_lvl = cnt_up;
        flags.dn_lvl = cnt_dn;
        flags.done   = $signed(acc_o) >= $signed(preset);
        flags.ovf    = ovf;
        flags.unf    = unf;
        flags.upd    = upd;
    end

    assign status = pack_status(flags);

    // R5: done moves only when the count or the preset moves
    a_r5_done_stable: assert property (@(posedge clk) disable iff (rst)
        ($stable(acc_o) && $stable(preset)) |-> $stable(status[BIT_DONE]));

    // R3: opposing edges leave the count alone
    a_r3_cancel: assert property (@(posedge clk) disable iff (rst)
        (rise == 2'b11 && !clr) |=> $stable(acc_o));

endmodule

// File: tb/evt_counter_test.sv
module evt_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_up = 1'b0;
    logic        cnt_dn = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] preset = '0;
    logic [15:0] acc_o;
    logic [15:0] status;

    always #4 clk = ~clk;

    evt_counter uut (
        .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
        .clr(clr), .preset(preset), .acc_o(acc_o), .status(status)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] q_acc[$];
    logic [15:0] q_st[$];
    string       q_tag[$];

    // reference model state
    logic signed [15:0] m_acc = '0;
    logic m_ovf = 0, m_unf = 0, m_upd = 0, m_pu = 0, m_pd = 0;

    task automatic step(input logic r, input logic u, input logic d,
                        input logic c, input logic [15:0] p, input string tag);
        logic ru, rd;
        @(negedge clk);
        rst = r; cnt_up = u; cnt_dn = d; clr = c; preset = p;
        if (r) begin
            m_acc = '0; m_ovf = 0; m_unf = 0; m_upd = 0; m_pu = 0; m_pd = 0;
        end else begin
            ru = u & ~m_pu;
            rd = d & ~m_pd;
            m_pu = u; m_pd = d;
            m_upd = 0;
            if (c) begin
                m_acc = '0; m_ovf = 0; m_unf = 0;
            end else if (ru && !rd) begin
                m_upd = 1;
                if (m_acc == 16'sh7FFF) begin m_acc = 16'sh8000; m_ovf = 1; end
                else m_acc = m_acc + 16'sd1;
            end else if (rd && !ru) begin
                m_upd = 1;
                if (m_acc == 16'sh8000) begin m_acc = 16'sh7FFF; m_unf = 1; end
                else m_acc = m_acc - 16'sd1;
            end
        end
        q_acc.push_back(m_acc);
        q_st.push_back({u, d, (m_acc >= $signed(p)), m_ovf, m_unf, m_upd, 10'b0});
        q_tag.push_back(tag);
    endtask

    // monitor: compare after each rising edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_acc.size() > 0) begin
                logic [15:0] ea, es;
                string t;
                ea = q_acc.pop_front();
                es = q_st.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (acc_o !== ea) begin
                    errors++;
                    $display("FAIL %s acc actual %0d expected %0d", t, $signed(acc_o), $signed(ea));
                end
                checks++;
                if (status !== es) begin
                    errors++;
                    $display("FAIL %s status actual %h expected %h", t, status, es);
                end
            end
        end
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        step(1, 0, 0, 0, 16'd2, "R11 reset");
        step(0, 0, 0, 0, 16'd2, "R11 idle after reset");
        // R1 up edge, held high counts once, R10 update pulse
        step(0, 1, 0, 0, 16'd2, "R1 R10 up edge");
        step(0, 1, 0, 0, 16'd2, "R1 held high");
        step(0, 1, 0, 0, 16'd2, "R1 R10 held high no update");
        step(0, 0, 0, 0, 16'd2, "R4 hold");
        step(0, 1, 0, 0, 16'd2, "R1 R5 second edge reaches preset");
        step(0, 0, 0, 0, 16'd2, "R4 R5 hold done");
        // R2 down edges, R9 level bits
        step(0, 0, 1, 0, 16'd2, "R2 R9 down edge");
        step(0, 0, 1, 0, 16'd2, "R2 R9 held down");
        step(0, 0, 0, 0, 16'd2, "R4 after down");
        step(0, 0, 1, 0, 16'd2, "R2 down to zero");
        step(0, 0, 0, 0, 16'd2, "R4");
        step(0, 0, 1, 0, 16'd2, "R2 below zero");
        step(0, 0, 0, 0, 16'd2, "R4");
        // R3 both edges in one cycle
        step(0, 1, 1, 0, 16'd2, "R3 both rise");
        step(0, 1, 1, 0, 16'd2, "R3 both held");
        step(0, 0, 0, 0, 16'd2, "R3 release");
        // R5 negative presets
        step(0, 0, 0, 0, 16'hFFFE, "R5 acc -1 vs -2");
        step(0, 0, 0, 0, 16'hFFFF, "R5 acc -1 vs -1");
        step(0, 0, 0, 0, 16'd0, "R5 acc -1 vs 0");
        step(0, 0, 1, 0, 16'hFFFF, "R2 R5 acc -2 vs -1");
        step(0, 0, 0, 0, 16'h8000, "R5 vs most negative");
        // R8 clear with a concurrent edge
        step(0, 1, 0, 1, 16'h7FFF, "R8 clear beats edge");
        step(0, 0, 0, 0, 16'h7FFF, "R8 after clear");
        // R6 run up to the top
        for (int i = 0; i < 32767; i++) begin
            step(0, 1, 0, 0, 16'h7FFF, "R1 R6 climb");
            step(0, 0, 0, 0, 16'h7FFF, "R4 R6 climb");
        end
        step(0, 1, 0, 0, 16'h7FFF, "R6 overflow wrap");
        step(0, 0, 0, 0, 16'h7FFF, "R6 flag held");
        step(0, 1, 0, 0, 16'h7FFF, "R6 sticky after count");
        step(0, 0, 0, 0, 16'h7FFF, "R6");
        step(0, 0, 1, 0, 16'h7FFF, "R6 back to min");
        step(0, 0, 0, 0, 16'h7FFF, "R6");
        // R7 below the bottom
        step(0, 0, 1, 0, 16'h7FFF, "R7 underflow wrap");
        step(0, 0, 0, 0, 16'h7FFF, "R7 flags held");
        step(0, 0, 1, 0, 16'h7FFF, "R7 sticky after count");
        step(0, 0, 0, 0, 16'h7FFF, "R7");
        step(0, 0, 0, 1, 16'h7FFF, "R8 clear flags");
        step(0, 0, 0, 0, 16'h7FFF, "R8 after clear");
        // R11 input high across reset counts once
        step(0, 1, 0, 0, 16'd0, "R1");
        step(1, 1, 0, 0, 16'd0, "R11 reset with input high");
        step(0, 1, 0, 0, 16'd0, "R11 first edge after reset");
        step(0, 1, 0, 0, 16'd0, "R11 held");
        step(0, 0, 0, 0, 16'd0, "R4");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule